// File: doc/BRIEF.md
# Memory-mapped to stream packet FIFO

This block is a first-in first-out buffer that joins a simple memory-mapped write port to a valid/ready streaming source. A bus master pushes 32-bit words by writing a fixed data offset, and each word later leaves on the stream side as one beat. The master frames packets through a control offset. It sets a start or end request there first, and that request is attached to the next data word the block accepts.

Each stored entry holds the word together with the two framing flags taken at the moment the word was accepted. A start request marks exactly one word and then drops, even if software never writes the control offset again. An end request behaves the same way, so one packet never passes its end mark to the next. When the buffer is full, a data write is held with waitrequest until the stream side drains an entry. Reads return the pending framing requests or the current fill level.

Top module: `mm2st_pkt_fifo`

## Requirements
- R1: While reset is asserted and after it is released, the buffer is empty. `st_valid` is low, the fill level reads 0, and both framing requests read 0.
- R2: An accepted write to word offset 0 (`mm_addr`=0) stores one 32-bit word. Words leave on `st_data` in the order they were written, with their values unchanged.
- R3: A write to word offset 1 (`mm_addr`=1) loads the framing requests: bit 0 is the start request and bit 1 is the end request. A read of offset 1 returns them in the same bit positions, with all other bits 0.
- R4: A start request marks only the first data word accepted after it (`st_sop`=1 on that beat). The request then clears itself, so later words carry `st_sop`=0.
- R5: An end request marks the next accepted data word (`st_eop`=1 on that beat) and then clears itself.
- R6: `st_valid` is high whenever the buffer holds an entry. An entry is removed only in a cycle where `st_valid` and `st_ready` are both high. While `st_valid` is high and `st_ready` is low, the beat stays unchanged, and `st_sop`/`st_eop` are never high without `st_valid`.
- R7: A data write while the buffer is full holds `mm_waitrequest` high. Neither the fill level nor the pending framing requests change until space frees and the write is accepted.
- R8: A read of offset 0 returns the number of stored entries, from 0 up to DEPTH.
- R9: A data write accepted in the same cycle as a stream pop leaves the fill level unchanged, and the new word joins the queue behind the older ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mm_addr | input | 1 | Word offset: 0 data/level, 1 framing control |
| mm_write | input | 1 | Write strobe |
| mm_read | input | 1 | Read strobe; read data is returned in the same cycle |
| mm_wdata | input | 32 | Write data |
| mm_rdata | output | 32 | Read data: fill level or framing requests |
| mm_waitrequest | output | 1 | Holds a data write while the buffer is full |
| st_data | output | 32 | Beat data |
| st_sop | output | 1 | Start-of-packet flag of the beat |
| st_eop | output | 1 | End-of-packet flag of the beat |
| st_valid | output | 1 | Beat available |
| st_ready | input | 1 | Sink accepts the beat |

## Verification
Two functions can land in the same clock edge: a data push from the bus and a pop on the stream side. The bench provokes this twice. First it holds a write against a full buffer and raises `st_ready` for one cycle, so the held write has to wait for that pop and then land on the freed slot. Then it drives a push and a pop in the same cycle on a partly filled buffer. In both cases it judges the result through the fill level read at offset 0, and through the order, data and end flag of the beats drained afterwards.

// File: rtl/mm2st_pkg.sv
package mm2st_pkg;
  typedef enum logic {
    OFS_DATA = 1'b0,
    OFS_CTRL = 1'b1
  } ofs_e;

  localparam int FLAG_SOP = 0;
  localparam int FLAG_EOP = 1;

  typedef struct packed {
    logic eop;
    logic sop;
  } frame_t;
endpackage

// File: rtl/mm2st_frame_ctl.sv
module mm2st_frame_ctl
  import mm2st_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  input  logic       push_acc,
  output frame_t     pend
);
  frame_t pend_q, pend_d;
  logic   pend_en;

  always_comb begin
    pend_en = ctl_wr | push_acc;
    pend_d  = pend_q;
    if (ctl_wr) begin
      pend_d.sop = ctl_wdata[FLAG_SOP];
      pend_d.eop = ctl_wdata[FLAG_EOP];
    end else if (push_acc) begin
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R4 R5
  flags_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && !ctl_wr) |=> (pend.sop == 1'b0 && pend.eop == 1'b0));

  // R3
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (pend.sop == $past(ctl_wdata[0]) && pend.eop == $past(ctl_wdata[1])));
endmodule

// File: rtl/mm2st_fifo_store.sv
module mm2st_fifo_store #(
  parameter int ENTRY_W = 34,
  parameter int DEPTH   = 16,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_entry,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head_entry,
  output logic               full,
  output logic               empty,
  output logic [LVL_W-1:0]   level
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]   rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic               ptr_en;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? ptr_step(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_step(rd_ptr_q) : rd_ptr_q;
    lvl_d    = lvl_q;
    if (push && !pop) begin
      lvl_d = lvl_q + 1'b1;
    end else if (pop && !push) begin
      lvl_d = lvl_q - 1'b1;
    end
    ptr_en = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      lvl_q    <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= push_entry;
    end
  end

  assign head_entry = mem[rd_ptr_q];
  assign full       = (lvl_q == LVL_W'(DEPTH));
  assign empty      = (lvl_q == '0);
  assign level      = lvl_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R9
  level_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(level));
endmodule

// File: rtl/mm2st_pkt_fifo.sv
module mm2st_pkt_fifo
  import mm2st_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int SYMS    = 4,
  parameter int DEPTH   = 16,
  localparam int DATA_W  = SYM_W * SYMS,
  localparam int ENTRY_W = DATA_W + 2,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mm_addr,
  input  logic              mm_write,
  input  logic              mm_read,
  input  logic [DATA_W-1:0] mm_wdata,
  output logic [DATA_W-1:0] mm_rdata,
  output logic              mm_waitrequest,
  output logic [DATA_W-1:0] st_data,
  output logic              st_sop,
  output logic              st_eop,
  output logic              st_valid,
  input  logic              st_ready
);
  logic               data_wr, ctl_wr, push, pop;
  logic               full, empty;
  logic [LVL_W-1:0]   level;
  frame_t             pend;
  logic [ENTRY_W-1:0] push_entry, head_entry;

  always_comb begin
    data_wr        = mm_write && (mm_addr == 1'(OFS_DATA));
    ctl_wr         = mm_write && (mm_addr == 1'(OFS_CTRL));
    mm_waitrequest = data_wr && full;
    push           = data_wr && !full;
    st_valid       = !empty;
    pop            = st_valid && st_ready;
    push_entry     = {pend.eop, pend.sop, mm_wdata};
  end

  mm2st_frame_ctl u_frame_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (mm_wdata[1:0]),
    .push_acc  (push),
    .pend      (pend)
  );

  mm2st_fifo_store #(
    .ENTRY_W (ENTRY_W),
    .DEPTH   (DEPTH)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_entry (push_entry),
    .pop        (pop),
    .head_entry (head_entry),
    .full       (full),
    .empty      (empty),
    .level      (level)
  );

  always_comb begin
    st_data = head_entry[DATA_W-1:0];
    st_sop  = st_valid & head_entry[DATA_W];
    st_eop  = st_valid & head_entry[DATA_W+1];
  end

  always_comb begin
    mm_rdata = '0;
    if (mm_read) begin
      if (mm_addr == 1'(OFS_CTRL)) begin
        mm_rdata[FLAG_SOP] = pend.sop;
        mm_rdata[FLAG_EOP] = pend.eop;
      end else begin
        mm_rdata = DATA_W'(level);
      end
    end
  end

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_sop) && $stable(st_eop)));

  // R6
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sop || st_eop) |-> st_valid);

  // R7
  stall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_waitrequest && !pop) |=> $stable(level));

  // R7
  stall_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mm_waitrequest |=> $stable(pend));
endmodule

// File: tb/mm2st_pkt_fifo_tb.sv
module mm2st_pkt_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int NVEC       = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mm_addr, mm_write, mm_read, mm_waitrequest;
  logic [31:0] mm_wdata, mm_rdata, st_data;
  logic        st_sop, st_eop, st_valid, st_ready;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm2st_pkt_fifo #(.SYM_W(8), .SYMS(4), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .mm_addr(mm_addr), .mm_write(mm_write),
    .mm_read(mm_read), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .mm_waitrequest(mm_waitrequest), .st_data(st_data), .st_sop(st_sop),
    .st_eop(st_eop), .st_valid(st_valid), .st_ready(st_ready)
  );

  // {ctl[1:0], exp_sop, exp_eop, data[31:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {2'b01, 1'b1, 1'b0, 32'hA000_0001},
    {2'b00, 1'b0, 1'b0, 32'hA000_0002},
    {2'b10, 1'b0, 1'b1, 32'hA000_0003},
    {2'b11, 1'b1, 1'b1, 32'hB0B0_0001},
    {2'b01, 1'b1, 1'b0, 32'hC000_0001},
    {2'b00, 1'b0, 1'b0, 32'hC000_0002},
    {2'b00, 1'b0, 1'b0, 32'hC000_0003},
    {2'b10, 1'b0, 1'b1, 32'hC000_0004}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic mm_wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    mm_addr = a; mm_wdata = d; mm_write = 1'b1;
    #1;
    while (mm_waitrequest) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 mm_write = 1'b0;
  endtask

  task automatic mm_rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    mm_addr = a; mm_read = 1'b1;
    #1 d = mm_rdata;
    mm_read = 1'b0;
  endtask

  task automatic pop_beat(output logic v, output logic [31:0] d, output logic s, output logic e);
    @(negedge clk);
    st_ready = 1'b1;
    #1 v = st_valid; d = st_data; s = st_sop; e = st_eop;
    @(posedge clk);
    #1 st_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, d;
    logic v, s, e;
    rst_n = 1'b0; mm_addr = 1'b0; mm_write = 1'b0; mm_read = 1'b0;
    mm_wdata = '0; st_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(st_valid == 1'b0, "R1 valid in reset", 32'(st_valid), 0);
    @(negedge clk) rst_n = 1'b1;

    mm_rd(1'b0, rd); chk(rd == 0, "R1 level after reset", rd, 0);
    mm_rd(1'b1, rd); chk(rd == 0, "R1 flags after reset", rd, 0);
    chk(st_valid == 1'b0, "R1 valid after reset", 32'(st_valid), 0);

    mm_wr(1'b1, 32'hFFFF_FFFF); mm_rd(1'b1, rd);
    chk(rd == 32'h3, "R3 flags readback", rd, 32'h3);
    mm_wr(1'b1, 32'h0); mm_rd(1'b1, rd);
    chk(rd == 32'h0, "R3 flags cleared by write", rd, 0);

    // vector walk: R2 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][35:34] != 2'b00) mm_wr(1'b1, {30'b0, VEC[i][35:34]});
      mm_wr(1'b0, VEC[i][31:0]);
      mm_rd(1'b0, rd);
      chk(rd == 32'(i + 1), "R8 level while filling", rd, 32'(i + 1));
    end
    mm_rd(1'b1, rd); chk(rd == 0, "R5 end request cleared", rd, 0);
    for (int i = 0; i < NVEC; i++) begin
      pop_beat(v, d, s, e);
      chk(v == 1'b1, "R6 valid when non-empty", 32'(v), 1);
      chk(d == VEC[i][31:0], "R2 beat data order", d, VEC[i][31:0]);
      chk(s == VEC[i][33], "R4 sop on beat", 32'(s), 32'(VEC[i][33]));
      chk(e == VEC[i][32], "R5 eop on beat", 32'(e), 32'(VEC[i][32]));
    end
    mm_rd(1'b0, rd); chk(rd == 0, "R8 level after drain", rd, 0);
    #1 chk(st_valid == 1'b0 && st_sop == 1'b0 && st_eop == 1'b0, "R6 no flags when empty",
           {29'b0, st_valid, st_sop, st_eop}, 0);

    // R6: ready while empty removes nothing; backpressure holds the beat
    @(negedge clk) st_ready = 1'b1;
    @(posedge clk); #1 st_ready = 1'b0;
    mm_rd(1'b0, rd); chk(rd == 0, "R6 pop on empty ignored", rd, 0);
    mm_wr(1'b1, 32'h1); mm_wr(1'b0, 32'h5555_0001);
    mm_wr(1'b0, 32'h5555_0002);
    repeat (2) @(posedge clk);
    #1 chk(st_valid && st_data == 32'h5555_0001 && st_sop, "R6 beat held under backpressure",
           st_data, 32'h5555_0001);
    mm_rd(1'b0, rd); chk(rd == 2, "R6 no pop without ready", rd, 2);
    pop_beat(v, d, s, e); pop_beat(v, d, s, e);
    chk(d == 32'h5555_0002 && !s, "R4 second word no sop", d, 32'h5555_0002);

    // R7: fill, then hold a write with an end request pending
    for (int i = 0; i < DEPTH; i++) mm_wr(1'b0, 32'h7000_0000 + 32'(i));
    mm_wr(1'b1, 32'h2);
    @(negedge clk);
    mm_addr = 1'b0; mm_wdata = 32'h7FFF_FFFF; mm_write = 1'b1; mm_read = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1 chk(mm_waitrequest == 1'b1, "R7 waitrequest when full", 32'(mm_waitrequest), 1);
      chk(mm_rdata == 32'(DEPTH), "R7 level held while stalled", mm_rdata, 32'(DEPTH));
      @(negedge clk);
    end
    st_ready = 1'b1;
    #1 chk(mm_waitrequest == 1'b1, "R7 stalled in pop cycle", 32'(mm_waitrequest), 1);
    @(posedge clk); #1 st_ready = 1'b0;
    #1 chk(mm_waitrequest == 1'b0, "R7 released after pop", 32'(mm_waitrequest), 0);
    @(posedge clk); #1 mm_write = 1'b0; mm_read = 1'b0;
    mm_rd(1'b0, rd); chk(rd == 32'(DEPTH), "R7 write landed after space", rd, 32'(DEPTH));
    mm_rd(1'b1, rd); chk(rd == 0, "R7 end request consumed once", rd, 0);
    for (int i = 1; i < DEPTH; i++) begin
      pop_beat(v, d, s, e);
      chk(d == 32'h7000_0000 + 32'(i) && !e, "R7 older beats intact", d, 32'h7000_0000 + 32'(i));
    end
    pop_beat(v, d, s, e);
    chk(d == 32'h7FFF_FFFF && e, "R7 stalled word carries eop", d, 32'h7FFF_FFFF);

    // R9: push and pop in one cycle
    mm_wr(1'b0, 32'h9000_0001);
    mm_wr(1'b0, 32'h9000_0002);
    @(negedge clk);
    mm_addr = 1'b0; mm_wdata = 32'h9000_0003; mm_write = 1'b1; st_ready = 1'b1;
    #1 chk(st_data == 32'h9000_0001, "R9 head before joint cycle", st_data, 32'h9000_0001);
    @(posedge clk); #1 mm_write = 1'b0; st_ready = 1'b0;
    mm_rd(1'b0, rd); chk(rd == 2, "R9 level unchanged", rd, 2);
    pop_beat(v, d, s, e); chk(d == 32'h9000_0002, "R9 order kept", d, 32'h9000_0002);
    pop_beat(v, d, s, e); chk(d == 32'h9000_0003, "R9 new word last", d, 32'h9000_0003);

    // R1: reset in mid-use empties the buffer
    mm_wr(1'b1, 32'h3); mm_wr(1'b0, 32'h1234_5678);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    mm_rd(1'b0, rd); chk(rd == 0, "R1 reset empties", rd, 0);
    mm_rd(1'b1, rd); chk(rd == 0, "R1 reset clears flags", rd, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule